// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Controller

This block sits beside the instruction sequencer of a small 8-bit core. It takes five hardware request lines and sorts them into one pending request per cycle, together with the 16-bit address the core should branch to. The highest line is non-maskable and needs both an edge and a level to count. Next come three maskable restart lines, called 7.5, 6.5 and 5.5 for their type numbers. The lowest is a general request line that carries no vector. When the core takes a request on the general line, the block pulses an active-low acknowledge, and the requesting device then supplies its own restart opcode.

A global enable is set and cleared by two command strobes. A three-bit mask register blocks the restart lines one by one. Taking any request clears the global enable. A separate combinational path turns a software restart number 0 to 7 into its vector, so the core can share the address arithmetic.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several requests qualify, the winner follows a fixed order from highest to lowest: non-maskable, 7.5, 6.5, 5.5, general. `irq_src_o` reports the winner as 0 = non-maskable, 1 = 7.5, 2 = 6.5, 3 = 5.5, 4 = general, and 7 when nothing is pending.
- R2: The non-maskable line qualifies whatever the mask bits and the global enable hold.
- R3: The non-maskable line qualifies only after a low-to-high change seen after reset, and only while it is still high. A line already high at reset does not fire. Once taken, it fires again only after it has gone low and risen again.
- R4: The vector is the type number times 8: non-maskable (type 4.5) gives 0024h, 7.5 gives 003Ch, 6.5 gives 0034h, 5.5 gives 002Ch. The general line gives 0000h and raises `irq_nv_o`.
- R5: `swr_vec_o` equals `swr_num_i` times 8 (0000h to 0038h), whatever the masks and the enable hold.
- R6: The global enable is cleared at reset, set by `ien_set_i` and cleared by `ien_clr_i`. While it is clear, no maskable line is pending.
- R7: The mask bits are `mask_val_i[2]` for 7.5, `[1]` for 6.5 and `[0]` for 5.5, and a 1 blocks the line. A pulse on `mask_wr_i` loads them only when `mask_upd_i` is 1. Reset sets all three bits.
- R8: A rising edge on the 7.5 line is latched and held after the line falls. The latch clears when that request is taken, or when a write on `mask_wr_i` carries `edge_clr_i` = 1.
- R9: The 6.5 and 5.5 lines are level sensitive. When the line falls before the request is taken, the pending request goes away.
- R10: Taking a general-line request drives `ack_n_o` low for exactly the one cycle after the take.
- R11: Taking any request clears the global enable. Taking the non-maskable request leaves the mask bits unchanged.
- R12: `irq_pend_o`, `irq_src_o` and `irq_vec_o` are registered together. They show a qualified request one cycle after it qualifies, with 0000h and source 7 while idle. They drop in the cycle after a take. A take while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request line |
| l7_i | input | 1 | Restart 7.5 request, edge latched |
| l6_i | input | 1 | Restart 6.5 request, level |
| l5_i | input | 1 | Restart 5.5 request, level |
| gen_i | input | 1 | General non-vectored request, level |
| ien_set_i | input | 1 | Enable-interrupts command strobe |
| ien_clr_i | input | 1 | Disable-interrupts command strobe |
| mask_wr_i | input | 1 | Mask port write strobe |
| mask_upd_i | input | 1 | Mask bits are loaded only when 1 |
| mask_val_i | input | 3 | Mask bits: [2] 7.5, [1] 6.5, [0] 5.5 |
| edge_clr_i | input | 1 | Clears the 7.5 latch on a mask port write |
| take_i | input | 1 | Core takes the pending request |
| swr_num_i | input | 3 | Software restart number |
| swr_vec_o | output | 16 | Software restart vector |
| irq_pend_o | output | 1 | A request is pending |
| irq_src_o | output | 3 | Pending source code |
| irq_vec_o | output | 16 | Pending vector address |
| irq_nv_o | output | 1 | Pending request is non-vectored |
| ack_n_o | output | 1 | Active-low acknowledge for the general line |

## Verification
A table drives every line at once under different mask patterns and enable states. Each row drops the highest line that is still live, which shows whether the bench has the order and vector of each level right, and which also tells a masked line apart from a disabled one. The non-maskable line is tested on its own in four ways: held high through reset, pulsed and dropped before the take, held high after the take, and re-raised. These runs separate the edge condition from the level condition. Directed runs also try short 7.5 pulses against the edge-clear path, falling level lines, mask writes with the update bit low, and takes with nothing pending.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W   = 16;
  localparam int SRC_W   = 3;
  localparam int NUM_SRC = 5;
  localparam int MASK_W  = 3;
  localparam int SWR_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NMI  = 3'd0,
    SRC_L7   = 3'd1,
    SRC_L6   = 3'd2,
    SRC_L5   = 3'd3,
    SRC_GEN  = 3'd4,
    SRC_NONE = 3'd7
  } irq_src_e;

  // Type number doubled, so that 4.5, 5.5 ... stay integers.
  function automatic logic [4:0] half_type(input irq_src_e s);
    case (s)
      SRC_NMI: half_type = 5'd9;
      SRC_L7:  half_type = 5'd15;
      SRC_L6:  half_type = 5'd13;
      SRC_L5:  half_type = 5'd11;
      default: half_type = 5'd0;
    endcase
  endfunction

  // type * 8 == (2 * type) * 4
  function automatic logic [VEC_W-1:0] hw_vector(input irq_src_e s);
    hw_vector = {{(VEC_W-5){1'b0}}, half_type(s)} << 2;
  endfunction

  function automatic logic [VEC_W-1:0] sw_vector(input logic [SWR_W-1:0] n);
    sw_vector = {{(VEC_W-SWR_W){1'b0}}, n} << 3;
  endfunction
endpackage

// File: rtl/irqv_qualify.sv
module irqv_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic l7_i,
  input  logic take_nmi,
  input  logic take_l7,
  input  logic edge_clr,
  output logic nmi_live,
  output logic l7_lat
);
  logic nmi_prev_q, nmi_arm_q, l7_prev_q, l7_lat_q;
  logic nmi_rise, l7_rise;

  assign nmi_rise = nmi_i & ~nmi_prev_q;
  assign l7_rise  = l7_i & ~l7_prev_q;

  // The previous value of the line resets high, so a line that is already high is not taken as an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      nmi_arm_q  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_i;
      if (take_nmi || !nmi_i)
        nmi_arm_q <= 1'b0;
      else if (nmi_rise)
        nmi_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l7_prev_q <= 1'b0;
      l7_lat_q  <= 1'b0;
    end else begin
      l7_prev_q <= l7_i;
      l7_lat_q  <= (l7_lat_q & ~(take_l7 | edge_clr)) | l7_rise;
    end
  end

  assign nmi_live = nmi_arm_q & nmi_i;
  assign l7_lat   = l7_lat_q;
endmodule

// File: rtl/irqv_mask_ctl.sv
module irqv_mask_ctl
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              mask_upd,
  input  logic [MASK_W-1:0] mask_val,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              take_any,
  output logic [MASK_W-1:0] mask_q,
  output logic              ien_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else if (mask_wr && mask_upd)
      mask_q <= mask_val;
  end

  // A clear, whether by command or by a take, wins over a set.
  always_ff @(posedge clk) begin
    if (!rst_n)
      ien_q <= 1'b0;
    else if (take_any || ien_clr)
      ien_q <= 1'b0;
    else if (ien_set)
      ien_q <= 1'b1;
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic [NUM_SRC-1:0] cand,
  output logic               win_valid,
  output irq_src_e           win_src,
  output logic [VEC_W-1:0]   win_vec
);
  // Index 0 is the highest priority. The loop runs from the lowest level up, so a higher level overwrites.
  always_comb begin
    win_src = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) win_src = irq_src_e'(i[SRC_W-1:0]);
    end
  end

  assign win_valid = |cand;
  assign win_vec   = hw_vector(win_src);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              l7_i,
  input  logic              l6_i,
  input  logic              l5_i,
  input  logic              gen_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              mask_wr_i,
  input  logic              mask_upd_i,
  input  logic [MASK_W-1:0] mask_val_i,
  input  logic              edge_clr_i,
  input  logic              take_i,
  input  logic [SWR_W-1:0]  swr_num_i,
  output logic [VEC_W-1:0]  swr_vec_o,
  output logic              irq_pend_o,
  output logic [SRC_W-1:0]  irq_src_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_nv_o,
  output logic              ack_n_o
);
  // Named internal events, also used by the checker
  logic              nmi_live, l7_lat;
  logic [MASK_W-1:0] mask_q;
  logic              ien_q;
  logic              take_ok, take_nmi, take_l7, take_gen;
  logic [NUM_SRC-1:0] cand;
  logic              win_valid;
  irq_src_e          win_src;
  logic [VEC_W-1:0]  win_vec;

  logic              pend_q, ack_n_q;
  irq_src_e          src_q;
  logic [VEC_W-1:0]  vec_q;

  assign take_ok  = take_i & pend_q;
  assign take_nmi = take_ok & (src_q == SRC_NMI);
  assign take_l7  = take_ok & (src_q == SRC_L7);
  assign take_gen = take_ok & (src_q == SRC_GEN);

  irqv_qualify u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_i    (nmi_i),
    .l7_i     (l7_i),
    .take_nmi (take_nmi),
    .take_l7  (take_l7),
    .edge_clr (mask_wr_i & edge_clr_i),
    .nmi_live (nmi_live),
    .l7_lat   (l7_lat)
  );

  irqv_mask_ctl u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_wr  (mask_wr_i),
    .mask_upd (mask_upd_i),
    .mask_val (mask_val_i),
    .ien_set  (ien_set_i),
    .ien_clr  (ien_clr_i),
    .take_any (take_ok),
    .mask_q   (mask_q),
    .ien_q    (ien_q)
  );

  assign cand[SRC_NMI] = nmi_live;
  assign cand[SRC_L7]  = l7_lat & ~mask_q[2] & ien_q;
  assign cand[SRC_L6]  = l6_i   & ~mask_q[1] & ien_q;
  assign cand[SRC_L5]  = l5_i   & ~mask_q[0] & ien_q;
  assign cand[SRC_GEN] = gen_i  & ien_q;

  irqv_arbiter u_arb (
    .cand      (cand),
    .win_valid (win_valid),
    .win_src   (win_src),
    .win_vec   (win_vec)
  );

  // Pending, source and vector load together. A take blanks them for one cycle while the state it cleared settles.
  always_ff @(posedge clk) begin
    if (!rst_n || take_ok || !win_valid) begin
      pend_q <= 1'b0;
      src_q  <= SRC_NONE;
      vec_q  <= '0;
    end else begin
      pend_q <= 1'b1;
      src_q  <= win_src;
      vec_q  <= win_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_n_q <= 1'b1;
    else        ack_n_q <= ~take_gen;
  end

  assign irq_pend_o = pend_q;
  assign irq_src_o  = src_q;
  assign irq_vec_o  = vec_q;
  assign irq_nv_o   = pend_q & (src_q == SRC_GEN);
  assign ack_n_o    = ack_n_q;
  assign swr_vec_o  = sw_vector(swr_num_i);
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_i,
  input logic              take_i,
  input logic              irq_pend_o,
  input logic [SRC_W-1:0]  irq_src_o,
  input logic              irq_nv_o,
  input logic              ack_n_o,
  input logic              nmi_live,
  input logic [MASK_W-1:0] mask_q,
  input logic              ien_q
);
  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_src_o == SRC_NMI) |-> $past(nmi_i)); // R3

  AST_PRIO_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_src_o != SRC_NMI) |-> !$past(nmi_live)); // R1

  AST_MASK_BLOCKS_L6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_src_o == SRC_L6) |-> $past(!mask_q[1] && ien_q)); // R7

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_src_o != SRC_NMI) |-> $past(ien_q)); // R6

  AST_TAKE_CLEARS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && irq_pend_o) |=> !ien_q); // R11

  AST_NMI_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && irq_pend_o && irq_src_o == SRC_NMI) |=> $stable(mask_q)); // R11

  AST_TAKE_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && irq_pend_o) |=> !irq_pend_o); // R12

  AST_ACK_ONLY_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> $past(take_i && irq_pend_o && irq_nv_o)); // R10

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_o) |=> ack_n_o); // R10
endmodule

bind irq_vector_ctrl irqv_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_i      (nmi_i),
  .take_i     (take_i),
  .irq_pend_o (irq_pend_o),
  .irq_src_o  (irq_src_o),
  .irq_nv_o   (irq_nv_o),
  .ack_n_o    (ack_n_o),
  .nmi_live   (nmi_live),
  .mask_q     (mask_q),
  .ien_q      (ien_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_i, l7_i, l6_i, l5_i, gen_i;
  logic ien_set_i, ien_clr_i, mask_wr_i, mask_upd_i, edge_clr_i, take_i;
  logic [2:0] mask_val_i, swr_num_i;
  logic [15:0] swr_vec_o, irq_vec_o;
  logic irq_pend_o, irq_nv_o, ack_n_o;
  logic [2:0] irq_src_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .l7_i(l7_i), .l6_i(l6_i),
    .l5_i(l5_i), .gen_i(gen_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .mask_wr_i(mask_wr_i), .mask_upd_i(mask_upd_i), .mask_val_i(mask_val_i),
    .edge_clr_i(edge_clr_i), .take_i(take_i), .swr_num_i(swr_num_i),
    .swr_vec_o(swr_vec_o), .irq_pend_o(irq_pend_o), .irq_src_o(irq_src_o),
    .irq_vec_o(irq_vec_o), .irq_nv_o(irq_nv_o), .ack_n_o(ack_n_o)
  );

  typedef struct packed {
    logic [2:0]  msk;
    logic        en;
    logic [4:0]  lines;   // {nmi, l7, l6, l5, gen}
    logic        pend;
    logic [2:0]  src;
    logic [15:0] vec;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{3'b000, 1'b1, 5'b11111, 1'b1, 3'd0, 16'h0024},
    '{3'b000, 1'b1, 5'b01111, 1'b1, 3'd1, 16'h003C},
    '{3'b000, 1'b1, 5'b00111, 1'b1, 3'd2, 16'h0034},
    '{3'b000, 1'b1, 5'b00011, 1'b1, 3'd3, 16'h002C},
    '{3'b000, 1'b1, 5'b00001, 1'b1, 3'd4, 16'h0000},
    '{3'b111, 1'b1, 5'b01111, 1'b1, 3'd4, 16'h0000},
    '{3'b000, 1'b0, 5'b01111, 1'b0, 3'd7, 16'h0000},
    '{3'b111, 1'b0, 5'b11111, 1'b1, 3'd0, 16'h0024},
    '{3'b100, 1'b1, 5'b01100, 1'b1, 3'd2, 16'h0034},
    '{3'b010, 1'b1, 5'b00110, 1'b1, 3'd3, 16'h002C}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {11'd0, irq_pend_o, irq_src_o, irq_vec_o, ack_n_o};
  endfunction

  function automatic logic [31:0] want(input logic p, input logic [2:0] s,
                                       input logic [15:0] v, input logic a);
    return {11'd0, p, s, v, a};
  endfunction

  task automatic clear_inputs();
    {nmi_i, l7_i, l6_i, l5_i, gen_i} = '0;
    {ien_set_i, ien_clr_i, mask_wr_i, mask_upd_i, edge_clr_i, take_i} = '0;
    mask_val_i = '0;
    swr_num_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic write_mask(input logic [2:0] m, input logic upd, input logic eclr);
    mask_wr_i = 1'b1; mask_upd_i = upd; mask_val_i = m; edge_clr_i = eclr;
    tick();
    mask_wr_i = 1'b0; mask_upd_i = 1'b0; edge_clr_i = 1'b0;
  endtask

  task automatic enable();
    ien_set_i = 1'b1;
    tick();
    ien_set_i = 1'b0;
  endtask

  task automatic take();
    take_i = 1'b1;
    tick();
    take_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    check("R12 reset idle", outs(), want(0, 3'd7, 16'h0, 1));

    // Table pass: priority, masks, enable, vectors
    for (int i = 0; i < NROWS; i++) begin
      clear_inputs();
      do_reset();
      write_mask(ROWS[i].msk, 1'b1, 1'b0);
      if (ROWS[i].en) enable();
      {nmi_i, l7_i, l6_i, l5_i, gen_i} = ROWS[i].lines;
      tick();
      tick();
      check($sformatf("R1 R2 R4 R6 R7 row %0d", i), outs(),
            want(ROWS[i].pend, ROWS[i].src, ROWS[i].vec, 1'b1));
    end

    // R5: software restart vectors
    for (int n = 0; n < 8; n++) begin
      swr_num_i = 3'(n);
      #1;
      check("R5 software vector", {16'd0, swr_vec_o}, 32'(n * 8));
    end

    // R6: the enable resets clear and is controlled by the commands
    clear_inputs(); do_reset();
    write_mask(3'b000, 1'b1, 1'b0);
    l6_i = 1'b1; tick(); tick();
    check("R6 disabled after reset", outs(), want(0, 3'd7, 16'h0, 1));
    enable(); tick();
    check("R6 enable command", outs(), want(1, 3'd2, 16'h0034, 1));
    ien_clr_i = 1'b1; tick(); ien_clr_i = 1'b0; tick();
    check("R6 disable command", outs(), want(0, 3'd7, 16'h0, 1));

    // R7: a mask write with the update bit low is ignored
    clear_inputs(); do_reset();
    write_mask(3'b000, 1'b0, 1'b0);
    enable();
    l5_i = 1'b1; tick(); tick();
    check("R7 mask write ignored", outs(), want(0, 3'd7, 16'h0, 1));
    write_mask(3'b000, 1'b1, 1'b0); tick();
    check("R7 mask write applied", outs(), want(1, 3'd3, 16'h002C, 1));

    // R9: a level line that falls before the take
    l5_i = 1'b0; tick();
    check("R9 level drop", outs(), want(0, 3'd7, 16'h0, 1));

    // R3: edge and level qualification of the non-maskable line
    clear_inputs();
    nmi_i = 1'b1;
    do_reset();
    tick();
    check("R3 high through reset", outs(), want(0, 3'd7, 16'h0, 1));
    nmi_i = 1'b0; tick();
    nmi_i = 1'b1; tick(); tick();
    check("R3 rising edge fires", outs(), want(1, 3'd0, 16'h0024, 1));
    nmi_i = 1'b0; tick();
    check("R3 drop before take", outs(), want(0, 3'd7, 16'h0, 1));
    nmi_i = 1'b1; tick(); tick();
    check("R3 second edge", outs(), want(1, 3'd0, 16'h0024, 1));
    take();
    check("R12 take drops pending", outs(), want(0, 3'd7, 16'h0, 1));
    tick(); tick();
    check("R3 held high no refire", outs(), want(0, 3'd7, 16'h0, 1));
    nmi_i = 1'b0; tick();
    nmi_i = 1'b1; tick(); tick();
    check("R3 refire after low", outs(), want(1, 3'd0, 16'h0024, 1));

    // R11: taking the non-maskable request clears the enable but keeps the mask
    clear_inputs(); do_reset();
    write_mask(3'b000, 1'b1, 1'b0);
    enable();
    nmi_i = 1'b1; tick(); tick();
    take();
    l6_i = 1'b1; tick(); tick();
    check("R11 enable cleared by take", outs(), want(0, 3'd7, 16'h0, 1));
    enable(); tick();
    check("R11 mask kept after take", outs(), want(1, 3'd2, 16'h0034, 1));

    // R8: the 7.5 latch holds after a short pulse and is cleared by a mask port write
    clear_inputs(); do_reset();
    write_mask(3'b000, 1'b1, 1'b0);
    enable();
    l7_i = 1'b1; tick(); l7_i = 1'b0; tick(); tick();
    check("R8 latch holds pulse", outs(), want(1, 3'd1, 16'h003C, 1));
    write_mask(3'b000, 1'b0, 1'b1); tick();
    check("R8 edge clear", outs(), want(0, 3'd7, 16'h0, 1));
    l7_i = 1'b1; tick(); l7_i = 1'b0; tick(); tick();
    take();
    enable(); tick();
    check("R8 latch cleared by take", outs(), want(0, 3'd7, 16'h0, 1));

    // R10, R12: general line handshake and a take with nothing pending
    clear_inputs(); do_reset();
    enable();
    take(); tick();
    check("R12 idle take ignored", outs(), want(0, 3'd7, 16'h0, 1));
    gen_i = 1'b1; tick();
    check("R10 general pending", {31'd0, irq_nv_o}, 32'd1);
    take();
    check("R10 ack low after take", outs(), want(0, 3'd7, 16'h0, 0));
    tick();
    check("R10 ack single cycle", {31'd0, ack_n_o}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule